// File: doc/BRIEF.md
# DMA Channel Control Register Front End

This block is the host-facing register set of one bus-master disk DMA channel. The host reaches it with byte-addressed I/O accesses one, two or four bytes wide. It holds three registers. The command register carries the run bit and the transfer direction. The status register carries the busy, error and interrupt flags. The base register holds the 32-bit address of the descriptor table in memory.

A separate descriptor walker moves the data, and this block steers it. When the host turns the run bit on, the block loads the walker's current table pointer from the base register. If the channel is idle, the block also marks it busy and sends the walker a one-cycle kick. When the host turns the run bit off, the transfer in progress is not aborted: the walker runs to its end and reports completion, and completion clears busy. Reset is the only way to abort, and it does so through a dedicated output.

The device interrupt passes straight through to the interrupt output. Its rising edge also latches the interrupt flag in status, where it stays until the host clears it.

Top module: `dcr_top`

## Requirements
- R1: The host map is byte-addressed on `reg_addr`: 0 is the command register, 1 is the status register, and 4 to 7 are the bytes of the base register. The access width on `reg_size` is 0 for one byte, 1 for two bytes and 2 for four bytes. The command register keeps only bits 0 (run) and 3 (direction) of a written byte and reads back that way. `run_en` mirrors bit 0 and `to_mem` mirrors bit 3.
- R2: A command write that turns the run bit from 0 to 1 while the channel is idle has three effects after that clock edge. `walk_ptr` equals the base register, status bit 0 (busy) and `chan_busy` are 1, and `walk_kick` is high for exactly one cycle.
- R3: A command write that turns the run bit from 0 to 1 while the channel is busy reloads `walk_ptr` from the base register and produces no kick.
- R4: A command write that leaves the run bit unchanged neither reloads `walk_ptr` nor kicks.
- R5: A command write that turns the run bit from 1 to 0 leaves busy set and does not assert `walk_abort`.
- R6: A base register write changes only the bytes covered by the access width, starting at byte offset `reg_addr[1:0]`, with data taken LSB-aligned from `wdata`. Bits 1:0 of the base register always read 0.
- R7: A base register read returns the stored value shifted right by 8 times `reg_addr[1:0]`, masked to the access width.
- R8: A rising edge on `dev_irq` sets status bit 2 (interrupt) one cycle later. `irq_out` follows `dev_irq` in both directions. A falling edge leaves status bit 2 unchanged.
- R9: Writing 1 to status bit 2 or bit 1 clears that bit. Status bit 0 cannot be changed by a host write.
- R10: A pulse on `walk_underrun` sets status bit 1 (error).
- R11: A pulse on `walk_done` clears busy.
- R12: Reset sets the command, status and base registers and `walk_ptr` to zero, and stops any kick. While reset is high and the channel is busy, `walk_abort` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 3 | Host byte address |
| reg_size | input | 2 | Access width: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| wdata | input | 32 | Write data, LSB-aligned |
| rdata | output | 32 | Read data, LSB-aligned, combinational from address |
| dev_irq | input | 1 | Interrupt level from the device |
| irq_out | output | 1 | Interrupt level forwarded to the host |
| walk_done | input | 1 | Walker reports the end of the transfer |
| walk_underrun | input | 1 | Walker reports the table ran out before the data |
| walk_kick | output | 1 | One-cycle start pulse to the walker |
| walk_ptr | output | 32 | Current table pointer loaded for the walker |
| walk_abort | output | 1 | Cancel of an active transfer during reset |
| run_en | output | 1 | Command run bit |
| to_mem | output | 1 | Command direction bit |
| chan_busy | output | 1 | Busy status bit |

## Verification
The base register gets a seeded random mix of offsets, widths and data, read back at other random offsets and widths. This separates errors in lane masking, in the read shift and in the forced-zero low bits. Directed command sequences check the four run-bit cases: an off-to-on change while idle, an off-to-on change while busy, a write that keeps the bit, and an on-to-off change. Each case is told apart by whether a kick appears and whether the pointer moves. A random interrupt-level stream checks that only rising edges latch the flag and that a falling edge leaves it set.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam logic [7:0] CMD_KEEP = 8'h09;
    localparam int RUN_BIT  = 0;
    localparam int DIR_BIT  = 3;
    localparam logic [ADDR_W-1:0] A_CMD  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_e;

    typedef struct packed {
        logic intr;
        logic err;
        logic busy;
    } stat_t;

    function automatic logic [DATA_W-1:0] width_mask(input logic [1:0] sz);
        case (sz)
            ACC_BYTE: width_mask = 32'h0000_00FF;
            ACC_HALF: width_mask = 32'h0000_FFFF;
            default:  width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [4:0] lane_shift(input logic [1:0] off);
        lane_shift = {off, 3'b000};
    endfunction

endpackage

// File: rtl/dcr_cmd.sv
module dcr_cmd
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wbyte,
    input  logic              busy,
    input  logic [DATA_W-1:0] base,
    output logic [7:0]        cmd,
    output logic              run_rise,
    output logic              kick,
    output logic [DATA_W-1:0] ptr
);
    assign run_rise = wr_en && wbyte[RUN_BIT] && !cmd[RUN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd  <= '0;
            kick <= 1'b0;
            ptr  <= '0;
        end else begin
            kick <= run_rise && !busy;
            if (wr_en)
                cmd <= wbyte & CMD_KEEP;
            if (run_rise)
                ptr <= base;
        end
    end
endmodule

// File: rtl/dcr_status.sv
module dcr_status
    import dcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wbyte,
    input  logic       set_busy,
    input  logic       done,
    input  logic       underrun,
    input  logic       dev_irq,
    output stat_t      st
);
    logic  irq_q;
    logic  irq_rise;
    stat_t st_n;

    assign irq_rise = dev_irq && !irq_q;

    always_comb begin
        st_n      = st;
        st_n.busy = set_busy ? 1'b1 : (done ? 1'b0 : st.busy);
        st_n.err  = underrun | (st.err  & ~(wr_en & wbyte[1]));
        st_n.intr = irq_rise | (st.intr & ~(wr_en & wbyte[2]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            irq_q <= 1'b0;
        end else begin
            st    <= st_n;
            irq_q <= dev_irq;
        end
    end
endmodule

// File: rtl/dcr_base.sv
module dcr_base
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        off,
    input  logic [1:0]        sz,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] rd_val
);
    logic [DATA_W-1:0] lanes;
    logic [DATA_W-1:0] placed;

    assign lanes  = width_mask(sz) << lane_shift(off);
    assign placed = (wdata << lane_shift(off)) & lanes & ~32'h3;
    assign rd_val = (base >> lane_shift(off)) & width_mask(sz);

    always_ff @(posedge clk) begin
        if (rst)
            base <= '0;
        else if (wr_en)
            base <= (base & ~lanes) | placed;
    end
endmodule

// File: rtl/dcr_top.sv
module dcr_top
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              dev_irq,
    output logic              irq_out,
    input  logic              walk_done,
    input  logic              walk_underrun,
    output logic              walk_kick,
    output logic [DATA_W-1:0] walk_ptr,
    output logic              walk_abort,
    output logic              run_en,
    output logic              to_mem,
    output logic              chan_busy
);
    logic              hit_cmd, hit_stat, hit_base;
    logic [7:0]        cmd_q;
    logic              run_rise;
    stat_t             st_q;
    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] base_rd;

    assign hit_cmd  = (reg_addr == A_CMD);
    assign hit_stat = (reg_addr == A_STAT);
    assign hit_base = reg_addr[2];

    dcr_cmd u_cmd (
        .clk(clk), .rst(rst), .wr_en(reg_wr && hit_cmd), .wbyte(wdata[7:0]),
        .busy(st_q.busy), .base(base_q), .cmd(cmd_q), .run_rise(run_rise),
        .kick(walk_kick), .ptr(walk_ptr)
    );

    dcr_status u_stat (
        .clk(clk), .rst(rst), .wr_en(reg_wr && hit_stat), .wbyte(wdata[7:0]),
        .set_busy(run_rise), .done(walk_done), .underrun(walk_underrun),
        .dev_irq(dev_irq), .st(st_q)
    );

    dcr_base u_base (
        .clk(clk), .rst(rst), .wr_en(reg_wr && hit_base), .off(reg_addr[1:0]),
        .sz(reg_size), .wdata(wdata), .base(base_q), .rd_val(base_rd)
    );

    always_comb begin
        if (hit_base)
            rdata = base_rd;
        else if (hit_cmd)
            rdata = {24'b0, cmd_q} & width_mask(reg_size);
        else if (hit_stat)
            rdata = {29'b0, st_q};
        else
            rdata = '0;
    end

    assign irq_out    = dev_irq;
    assign walk_abort = rst && st_q.busy;
    assign run_en     = cmd_q[RUN_BIT];
    assign to_mem     = cmd_q[DIR_BIT];
    assign chan_busy  = st_q.busy;
endmodule

// File: rtl/dcr_chk.sv
module dcr_chk
    import dcr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              dev_irq,
    input logic              walk_done,
    input logic              walk_kick,
    input logic              chan_busy,
    input logic [DATA_W-1:0] walk_ptr,
    input logic [DATA_W-1:0] base_q,
    input stat_t             st_q
);
    // R2
    kick_busy_chk: assert property (@(posedge clk) disable iff (rst)
        walk_kick |-> chan_busy);

    // R3
    kick_idle_chk: assert property (@(posedge clk) disable iff (rst)
        walk_kick |-> !$past(chan_busy));

    // R6
    base_align_chk: assert property (@(posedge clk) disable iff (rst)
        base_q[1:0] == 2'b00);

    // R8
    irq_latch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_irq) |=> st_q.intr);

    // R11
    done_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_done && !(reg_wr && reg_addr == A_CMD)) |=> !chan_busy);

    // R12
    rst_clr_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!chan_busy && walk_ptr == '0 && base_q == '0 && !walk_kick));
endmodule

bind dcr_top dcr_chk u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .dev_irq(dev_irq), .walk_done(walk_done), .walk_kick(walk_kick),
    .chan_busy(chan_busy), .walk_ptr(walk_ptr), .base_q(base_q), .st_q(st_q)
);

// File: tb/dcr_top_bench.sv
`timescale 1ns/1ps
module dcr_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        dev_irq = 1'b0;
    logic        irq_out;
    logic        walk_done = 1'b0;
    logic        walk_underrun = 1'b0;
    logic        walk_kick;
    logic [31:0] walk_ptr;
    logic        walk_abort;
    logic        run_en;
    logic        to_mem;
    logic        chan_busy;

    int tests = 0;
    int fails = 0;
    logic [31:0] m_base = '0;
    logic        m_int = 1'b0;
    logic        prev_irq = 1'b0;

    always #2 clk = ~clk;

    dcr_top u_dcr_top (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size(reg_size), .wdata(wdata), .rdata(rdata), .dev_irq(dev_irq),
        .irq_out(irq_out), .walk_done(walk_done), .walk_underrun(walk_underrun),
        .walk_kick(walk_kick), .walk_ptr(walk_ptr), .walk_abort(walk_abort),
        .run_en(run_en), .to_mem(to_mem), .chan_busy(chan_busy)
    );

    function automatic logic [31:0] bwm(input logic [1:0] s);
        return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_size = s; wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] v);
        reg_addr = a; reg_size = s;
        #1;
        v = rdata;
    endtask

    task automatic pulse(input bit which);
        @(negedge clk);
        if (which) walk_done = 1'b1; else walk_underrun = 1'b1;
        @(negedge clk);
        walk_done = 1'b0; walk_underrun = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        rd(3'd0, 2'd0, v); chk("R12 cmd after reset", v, 0);
        rd(3'd1, 2'd0, v); chk("R12 status after reset", v, 0);
        rd(3'd4, 2'd2, v); chk("R12 base after reset", v, 0);
        chk("R12 kick/ptr after reset", {walk_kick, walk_ptr[30:0]}, 0);

        // R1 command masking
        wr(3'd0, 2'd0, 32'hF6);
        rd(3'd0, 2'd0, v); chk("R1 cmd keeps bits 0,3 (F6)", v, 32'h00);
        wr(3'd0, 2'd0, 32'hFE);
        rd(3'd0, 2'd0, v); chk("R1 cmd keeps bits 0,3 (FE)", v, 32'h08);
        chk("R1 to_mem", to_mem, 1);
        chk("R1 run_en", run_en, 0);
        wr(3'd0, 2'd0, 32'h00);

        // R6 R7 random base lanes
        for (int i = 0; i < 60; i++) begin
            logic [1:0] o, s, o2, s2;
            logic [31:0] d, msk;
            o = 2'($urandom_range(0, 3)); s = 2'($urandom_range(0, 2));
            d = $urandom;
            msk = bwm(s) << (8 * o);
            m_base = (m_base & ~msk) | ((d << (8 * o)) & msk & ~32'h3);
            wr({1'b1, o}, s, d);
            o2 = 2'($urandom_range(0, 3)); s2 = 2'($urandom_range(0, 2));
            rd({1'b1, o2}, s2, v);
            chk("R7 base shifted read", v, (m_base >> (8 * o2)) & bwm(s2));
            rd(3'd4, 2'd2, v);
            chk("R6 base lanes and low bits", v, m_base);
        end

        // R2 start while idle
        wr(3'd4, 2'd2, 32'h1234_5677); m_base = 32'h1234_5674;
        wr(3'd0, 2'd0, 32'h01);
        chk("R2 kick pulse", walk_kick, 1);
        chk("R2 ptr loaded", walk_ptr, m_base);
        chk("R2 busy", chan_busy, 1);
        rd(3'd1, 2'd0, v); chk("R2 status busy bit 0", v & 1, 1);
        @(negedge clk);
        chk("R2 kick one cycle", walk_kick, 0);

        // R4 unchanged run bit
        wr(3'd4, 2'd2, 32'hA0);
        wr(3'd0, 2'd0, 32'h01);
        chk("R4 no reload", walk_ptr, m_base);
        chk("R4 no kick", walk_kick, 0);

        // R5 stop does not abort
        wr(3'd0, 2'd0, 32'h00);
        chk("R5 busy kept", chan_busy, 1);
        chk("R5 no abort", walk_abort, 0);
        chk("R5 run_en low", run_en, 0);

        // R3 restart while busy
        wr(3'd0, 2'd0, 32'h01);
        chk("R3 ptr reloaded", walk_ptr, 32'hA0);
        chk("R3 no kick", walk_kick, 0);

        // R9 busy is read-only
        wr(3'd1, 2'd0, 32'h07);
        rd(3'd1, 2'd0, v); chk("R9 busy not host-writable", v, 32'h1);

        // R11 done clears busy
        pulse(1'b1);
        chk("R11 busy cleared", chan_busy, 0);

        // R10 underrun, R9 clear
        pulse(1'b0);
        rd(3'd1, 2'd0, v); chk("R10 error set", v, 32'h2);
        wr(3'd1, 2'd0, 32'h02);
        rd(3'd1, 2'd0, v); chk("R9 error W1C", v, 32'h0);

        // R8 directed
        @(negedge clk); dev_irq = 1'b1; #1;
        chk("R8 irq_out rises", irq_out, 1);
        @(negedge clk);
        rd(3'd1, 2'd0, v); chk("R8 int latched", v, 32'h4);
        dev_irq = 1'b0; #1;
        chk("R8 irq_out falls", irq_out, 0);
        @(negedge clk);
        rd(3'd1, 2'd0, v); chk("R8 int kept after fall", v, 32'h4);
        wr(3'd1, 2'd0, 32'h04);
        rd(3'd1, 2'd0, v); chk("R9 int W1C", v, 32'h0);

        // R8 random irq stream
        m_int = 1'b0; prev_irq = 1'b0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            rd(3'd1, 2'd0, v);
            chk("R8 int vs model", v[2], m_int);
            chk("R8 forward", irq_out, dev_irq);
            dev_irq = 1'($urandom_range(0, 1));
            if (dev_irq && !prev_irq) m_int = 1'b1;
            prev_irq = dev_irq;
            if ((i % 17) == 16) begin
                @(negedge clk);
                if (dev_irq && !prev_irq) m_int = 1'b1;
                rd(3'd1, 2'd0, v);
                chk("R8 int vs model pre-clear", v[2], m_int);
                reg_wr = 1'b1; reg_addr = 3'd1; wdata = 32'h04;
                @(negedge clk);
                reg_wr = 1'b0;
                m_int = 1'b0;
            end
        end
        dev_irq = 1'b0;
        @(negedge clk); @(negedge clk);

        // R12 reset while busy
        wr(3'd0, 2'd0, 32'h00);
        wr(3'd0, 2'd0, 32'h09);
        chk("R12 busy before reset", chan_busy, 1);
        rst = 1'b1; #1;
        chk("R12 abort during reset", walk_abort, 1);
        @(negedge clk);
        rst = 1'b0;
        rd(3'd0, 2'd0, v); chk("R12 cmd cleared", v, 0);
        rd(3'd4, 2'd2, v); chk("R12 base cleared", v, 0);
        rd(3'd1, 2'd0, v); chk("R12 status cleared", v, 0);
        chk("R12 ptr cleared", walk_ptr, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule